// File: doc/BRIEF.md
# Multi-Mode Bit Clock Recovery Loop

This block regenerates a bit-rate receive clock from the transitions of a receive bit stream that has already been sliced to one bit. A phase accumulator counts oversampling ticks, and each transition of the input moves it back toward the point where a transition is expected. A small mode controller sets how far one pair of transitions may move the phase. Two inputs drive it: an acquire strobe and an active-low hold. While acquire is high the loop reacts fast. When acquire falls, the loop runs at medium gain for a fixed number of recovered bits and then drops to narrow gain. With hold low the loop opens, and the clock runs on at the nominal rate through a fade.

The block also samples the input at mid-bit to produce retimed data, which is stable at each rising edge of the recovered clock. It rates every transition as good or bad by how far the transition lands from its predicted time, and drives a one-bit quality flag from that rating. A powersave input clears the data and quality outputs and stops loop correction, but the clock keeps running. In use, a controller raises acquire during a preamble, lowers it once lock is reached, and pulls hold low when the carrier fades.

Top module: `bitclk_dpll`

## Requirements
- R1: With acq high, mode reads 0 (acquire). Each second transition may move the phase by at most 16/256 of a bit, so an offset of a fraction of a bit is removed and the rx_clk rising edge lines up with the input transitions.
- R2: When acq falls while hold_n is 1, mode reads 1 (medium). Each second transition may then move the phase by at most 4/256 of a bit.
- R3: Medium mode lasts for 30 rising edges of rx_clk after the fall of acq. After that, mode reads 2 (narrow), and each second transition may move the phase by at most 1/256 of a bit.
- R4: Each new falling edge of acq restarts the 30-bit medium window from its beginning.
- R5: With acq at 0 and hold_n at 0, mode reads 3 (freewheel). The phase then advances by exactly 1/64 of a bit per tick, so rx_clk rising edges are 64 ticks apart, and input transitions do not move them.
- R6: hold_n has no effect while acq is 1: mode stays 0 and the loop keeps correcting.
- R7: While psave is 1, rx_data and quality read 0 from the next clock onward, no phase correction is applied, and rx_clk keeps toggling.
- R8: A transition that lands within ±1/8 bit (±32/256) of the predicted bit boundary sets quality to 1. One that lands farther away clears it.
- R9: rx_data takes the input at mid-bit (accumulator half-way point) and holds it, so at each rx_clk rising edge it carries the bit that has just ended.
- R10: The accumulator advances only on cycles with sample_tick high. Without ticks, rx_clk does not change.
- R11: During reset, rx_clk reads 1, rx_data and quality read 0, and mode reads 2 when acq is 0 and hold_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Oversampling enable, 64 per nominal bit |
| rx_slice | input | 1 | Sliced receive bit stream |
| acq | input | 1 | Acquire strobe, high for fast lock |
| hold_n | input | 1 | Active-low hold; low opens the loop when acq is 0 |
| psave | input | 1 | Powersave; clears data and quality, stops correction |
| rx_clk | output | 1 | Recovered bit clock, rises at the bit boundary |
| rx_data | output | 1 | Retimed data, valid at the rx_clk rising edge |
| quality | output | 1 | 1 after a good transition, 0 after a bad one |
| mode | output | 2 | Loop mode: 0 acquire, 1 medium, 2 narrow, 3 freewheel |

## Verification
A wrong gain limit shows up at the ports as a residual lag between input transitions and rx_clk rising edges. A known timing step is applied, and after four correction pairs that lag sits several clocks away from the expected value, so it is caught within about nine bits. A bad window counter makes mode switch to narrow a whole number of rx_clk rises early or late, which is visible as soon as the window ends. A leak in freewheel or powersave moves the spacing of rx_clk edges on the first bit after the step. A sampling-point error gives rx_data different from the ended bit at the first rx_clk rise.

// File: rtl/bitclk_dpll_pkg.sv
package bitclk_dpll_pkg;

   typedef enum logic [1:0] {
      MODE_ACQ  = 2'd0,
      MODE_MED  = 2'd1,
      MODE_NAR  = 2'd2,
      MODE_FREE = 2'd3
   } loop_mode_t;

endpackage

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
   import bitclk_dpll_pkg::*;
#(
   parameter int MED_BITS = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acq_i,
   input  logic       hold_n_i,
   input  logic       bit_tick_i,
   output loop_mode_t mode_o
);

   localparam int CNT_W = $clog2(MED_BITS + 1);

   logic             acq_d;
   logic [CNT_W-1:0] win_cnt;
   logic             acq_fall;

   assign acq_fall = acq_d & ~acq_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acq_d   <= 1'b0;
         win_cnt <= '0;
      end else begin
         acq_d <= acq_i;
         if (acq_fall)
            win_cnt <= CNT_W'(MED_BITS);
         else if (bit_tick_i && win_cnt != '0)
            win_cnt <= win_cnt - 1'b1;
      end
   end

   always_comb begin
      if (acq_i)
         mode_o = MODE_ACQ;
      else if (!hold_n_i)
         mode_o = MODE_FREE;
      else if (acq_fall || win_cnt != '0)
         mode_o = MODE_MED;
      else
         mode_o = MODE_NAR;
   end

endmodule

// File: rtl/dpll_phase_acc.sv
module dpll_phase_acc
   import bitclk_dpll_pkg::*;
#(
   parameter int PHASE_BITS = 6,
   parameter int FRAC_BITS  = 2,
   parameter int ACQ_LIM    = 16,
   parameter int MED_LIM    = 4,
   parameter int NAR_LIM    = 1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     tick_i,
   input  logic                                     slice_i,
   input  loop_mode_t                               mode_i,
   input  logic                                     psave_i,
   output logic [PHASE_BITS+FRAC_BITS-1:0]          phase_o,
   output logic                                     xing_o,
   output logic signed [PHASE_BITS+FRAC_BITS:0]     err_o,
   output logic                                     bit_start_o,
   output logic                                     mid_bit_o
);

   localparam int ACC_W = PHASE_BITS + FRAC_BITS;
   localparam int STEP  = 1 << FRAC_BITS;

   logic [ACC_W-1:0]        phase_q;
   logic [ACC_W-1:0]        phase_nx;
   logic                    last_q;
   logic                    pair_q;
   logic                    closed;
   logic                    apply;
   logic signed [ACC_W:0]   err_x;
   logic signed [ACC_W:0]   lim_x;
   logic signed [ACC_W:0]   cor_x;
   logic [ACC_W:0]          sum_w;

   assign xing_o = tick_i & (slice_i != last_q);
   assign err_x  = {phase_q[ACC_W-1], phase_q};
   assign closed = (mode_i != MODE_FREE) & ~psave_i;
   assign apply  = xing_o & closed & pair_q;

   always_comb begin
      case (mode_i)
         MODE_ACQ: lim_x = (ACC_W+1)'(ACQ_LIM);
         MODE_MED: lim_x = (ACC_W+1)'(MED_LIM);
         MODE_NAR: lim_x = (ACC_W+1)'(NAR_LIM);
         default:  lim_x = '0;
      endcase
      if (err_x > lim_x)
         cor_x = lim_x;
      else if (err_x < -lim_x)
         cor_x = -lim_x;
      else
         cor_x = err_x;
      sum_w = {1'b0, phase_q} + (ACC_W+1)'(STEP)
              - (apply ? $unsigned(cor_x) : '0);
      phase_nx = sum_w[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         last_q  <= 1'b0;
         pair_q  <= 1'b0;
      end else if (tick_i) begin
         phase_q <= phase_nx;
         last_q  <= slice_i;
         if (xing_o && closed)
            pair_q <= ~pair_q;
      end
   end

   assign phase_o     = phase_q;
   assign err_o       = err_x;
   assign bit_start_o = tick_i & phase_q[ACC_W-1] & ~phase_nx[ACC_W-1];
   assign mid_bit_o   = tick_i & ~phase_q[ACC_W-1] & phase_nx[ACC_W-1];

endmodule

// File: rtl/dpll_quality.sv
module dpll_quality #(
   parameter int ACC_W    = 8,
   parameter int GOOD_WIN = 32,
   parameter int GOOD_RUN = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    xing_i,
   input  logic signed [ACC_W:0]   err_i,
   input  logic                    psave_i,
   output logic                    good_o
);

   localparam int RUN_W = $clog2(GOOD_RUN + 1);

   logic signed [ACC_W:0] win_x;
   logic                  in_win;

   assign win_x  = (ACC_W+1)'(GOOD_WIN);
   assign in_win = (err_i <= win_x) && (err_i >= -win_x);

   generate
      if (GOOD_RUN <= 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n || psave_i)
               q <= 1'b0;
            else if (xing_i)
               q <= in_win;
         end
         assign good_o = q;
      end else begin : g_run
         logic [RUN_W-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n || psave_i)
               run_q <= '0;
            else if (xing_i) begin
               if (!in_win)
                  run_q <= '0;
               else if (run_q != RUN_W'(GOOD_RUN))
                  run_q <= run_q + 1'b1;
            end
         end
         assign good_o = (run_q == RUN_W'(GOOD_RUN));
      end
   endgenerate

endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
   import bitclk_dpll_pkg::*;
#(
   parameter int PHASE_BITS = 6,
   parameter int FRAC_BITS  = 2,
   parameter int ACQ_LIM    = 16,
   parameter int MED_LIM    = 4,
   parameter int NAR_LIM    = 1,
   parameter int MED_BITS   = 30,
   parameter int GOOD_WIN   = 32,
   parameter int GOOD_RUN   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_tick,
   input  logic       rx_slice,
   input  logic       acq,
   input  logic       hold_n,
   input  logic       psave,
   output logic       rx_clk,
   output logic       rx_data,
   output logic       quality,
   output logic [1:0] mode
);

   localparam int ACC_W = PHASE_BITS + FRAC_BITS;
   localparam int HALF  = 1 << (ACC_W - 1);

   generate
      if (PHASE_BITS < 4) begin : g_chk_pb
         $error("PHASE_BITS must be at least 4");
      end
      if (!(ACQ_LIM >= MED_LIM && MED_LIM >= NAR_LIM && NAR_LIM >= 1)) begin : g_chk_lim
         $error("loop limits must satisfy ACQ_LIM >= MED_LIM >= NAR_LIM >= 1");
      end
      if (ACQ_LIM >= HALF || GOOD_WIN >= HALF) begin : g_chk_win
         $error("limits and quality window must stay below half a bit");
      end
      if (MED_BITS < 1) begin : g_chk_med
         $error("MED_BITS must be at least 1");
      end
   endgenerate

   loop_mode_t            cur_mode;
   logic [ACC_W-1:0]      phase;
   logic                  xing;
   logic signed [ACC_W:0] xing_err;
   logic                  bit_start;
   logic                  mid_bit;
   logic                  data_q;

   dpll_mode_ctrl #(
      .MED_BITS (MED_BITS)
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .acq_i      (acq),
      .hold_n_i   (hold_n),
      .bit_tick_i (bit_start),
      .mode_o     (cur_mode)
   );

   dpll_phase_acc #(
      .PHASE_BITS (PHASE_BITS),
      .FRAC_BITS  (FRAC_BITS),
      .ACQ_LIM    (ACQ_LIM),
      .MED_LIM    (MED_LIM),
      .NAR_LIM    (NAR_LIM)
   ) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (sample_tick),
      .slice_i     (rx_slice),
      .mode_i      (cur_mode),
      .psave_i     (psave),
      .phase_o     (phase),
      .xing_o      (xing),
      .err_o       (xing_err),
      .bit_start_o (bit_start),
      .mid_bit_o   (mid_bit)
   );

   dpll_quality #(
      .ACC_W    (ACC_W),
      .GOOD_WIN (GOOD_WIN),
      .GOOD_RUN (GOOD_RUN)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .xing_i  (xing),
      .err_i   (xing_err),
      .psave_i (psave),
      .good_o  (quality)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || psave)
         data_q <= 1'b0;
      else if (mid_bit)
         data_q <= rx_slice;
   end

   assign rx_clk  = ~phase[ACC_W-1];
   assign rx_data = data_q;
   assign mode    = cur_mode;

endmodule

// File: rtl/bitclk_dpll_chk.sv
module bitclk_dpll_chk #(
   parameter int ACC_W   = 8,
   parameter int STEP    = 4,
   parameter int ACQ_LIM = 16,
   parameter int MED_LIM = 4,
   parameter int NAR_LIM = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_tick,
   input logic             acq,
   input logic             hold_n,
   input logic             psave,
   input logic             rx_clk,
   input logic             rx_data,
   input logic             quality,
   input logic [1:0]       mode,
   input logic [ACC_W-1:0] phase
);

   logic [ACC_W-1:0]        ph_prev;
   logic [1:0]              md_prev;
   logic                    tk_prev;
   logic                    vld;
   logic signed [ACC_W-1:0] dev;
   logic [ACC_W:0]          dev_abs;
   logic [ACC_W:0]          lim_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         ph_prev <= '0;
         md_prev <= 2'd0;
         tk_prev <= 1'b0;
      end else begin
         vld     <= 1'b1;
         ph_prev <= phase;
         md_prev <= mode;
         tk_prev <= sample_tick;
      end
   end

   always_comb begin
      dev     = signed'(phase - ph_prev - ACC_W'(STEP));
      dev_abs = dev[ACC_W-1] ? (ACC_W+1)'(-{dev[ACC_W-1], dev}) : (ACC_W+1)'(dev);
      case (md_prev)
         2'd0:    lim_prev = (ACC_W+1)'(ACQ_LIM);
         2'd1:    lim_prev = (ACC_W+1)'(MED_LIM);
         2'd2:    lim_prev = (ACC_W+1)'(NAR_LIM);
         default: lim_prev = '0;
      endcase
   end

   p_acq_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acq |-> mode == 2'd0);

   p_hold_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acq && !hold_n) |-> mode == 2'd0);

   p_corr_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && tk_prev) |-> dev_abs <= lim_prev);

   p_free_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && tk_prev && md_prev == 2'd3) |-> dev == '0);

   p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(rx_clk));

   p_psave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      psave |=> (!rx_data && !quality));

endmodule

bind bitclk_dpll bitclk_dpll_chk #(
   .ACC_W   (ACC_W),
   .STEP    (1 << FRAC_BITS),
   .ACQ_LIM (ACQ_LIM),
   .MED_LIM (MED_LIM),
   .NAR_LIM (NAR_LIM)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_tick (sample_tick),
   .acq         (acq),
   .hold_n      (hold_n),
   .psave       (psave),
   .rx_clk      (rx_clk),
   .rx_data     (rx_data),
   .quality     (quality),
   .mode        (mode),
   .phase       (phase)
);

// File: tb/tb_bitclk_dpll.sv
`timescale 1ns/1ps
module tb_bitclk_dpll;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b1;
   logic       rx_slice = 1'b0;
   logic       acq = 1'b0;
   logic       hold_n = 1'b1;
   logic       psave = 1'b0;
   logic       rx_clk;
   logic       rx_data;
   logic       quality;
   logic [1:0] mode;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   int cyc = 0;
   int tx_off = 20;
   bit gen_on = 1'b0;
   bit pat_pairs = 1'b0;
   int bidx = 0;
   int n_bound = 0;
   int n_rise = 0;
   int last_rise = 0;
   int rise_gap = 0;
   int last_lag = 0;
   int data_chk = 0;
   bit clk_prev = 1'b1;

   // {acq, hold_n, expected mode}
   localparam logic [3:0] MODE_VEC [8] = '{
      4'b01_10, 4'b11_00, 4'b10_00, 4'b00_11,
      4'b01_01, 4'b00_11, 4'b01_01, 4'b11_00
   };

   bitclk_dpll dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .rx_slice    (rx_slice),
      .acq         (acq),
      .hold_n      (hold_n),
      .psave       (psave),
      .rx_clk      (rx_clk),
      .rx_data     (rx_data),
      .quality     (quality),
      .mode        (mode)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc_wait(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_bounds(input int n);
      int target;
      target = n_bound + n;
      while (n_bound < target) cyc_wait(1);
   endtask

   task automatic wait_rises(input int n);
      int target;
      target = n_rise + n;
      while (n_rise < target) cyc_wait(1);
   endtask

   // stimulus generator and edge monitor, all at the falling clock edge
   initial begin
      forever begin
         @(negedge clk);
         if (rx_clk && !clk_prev) begin
            n_rise++;
            rise_gap  = cyc - last_rise;
            last_rise = cyc;
            if (data_chk > 0) begin
               // R9: at the rise rx_data carries the bit now ending
               check(rx_data == rx_slice, "R9 retimed data", int'(rx_data), int'(rx_slice));
               data_chk--;
            end
         end
         clk_prev = rx_clk;
         if (gen_on && ((cyc - tx_off) % 64 == 0)) begin
            logic nb;
            n_bound++;
            bidx++;
            nb = pat_pairs ? ~bidx[1] : bidx[0];
            if (nb != rx_slice) begin
               int lag;
               lag = cyc - last_rise;
               if (lag > 32) lag -= 64;
               last_lag = lag;
            end
            rx_slice = nb;
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int r0;
      int l0;
      int guard;
      logic c0;

      // R11: reset state
      cyc_wait(3);
      check(rx_clk == 1'b1, "R11 rx_clk in reset", int'(rx_clk), 1);
      check(rx_data == 1'b0, "R11 rx_data in reset", int'(rx_data), 0);
      check(quality == 1'b0, "R11 quality in reset", int'(quality), 0);
      check(mode == 2'd2, "R11 mode in reset", int'(mode), 2);
      @(negedge clk);
      rst_n = 1'b1;
      cyc_wait(1);

      // mode table: R1 R2 R5 R6
      for (int i = 0; i < 8; i++) begin
         acq    = MODE_VEC[i][3];
         hold_n = MODE_VEC[i][2];
         cyc_wait(3);
         check(mode == MODE_VEC[i][1:0], "R1/R2/R5/R6 mode table", int'(mode), int'(MODE_VEC[i][1:0]));
      end

      // R1: acquire lock
      acq = 1'b1; hold_n = 1'b1;
      gen_on = 1'b1;
      wait_bounds(40);
      check(last_lag >= -1 && last_lag <= 1, "R1 acquire lock lag", last_lag, 0);
      check(quality == 1'b1, "R8 good after lock", int'(quality), 1);

      // R2: medium gain, step of 8 clocks, 4 corrections of 1 clock
      wait_bounds(1);
      acq = 1'b0;
      tx_off += 8;
      cyc_wait(1);
      check(mode == 2'd1, "R2 medium after acq fall", int'(mode), 1);
      wait_bounds(9);
      check(last_lag >= 3 && last_lag <= 5, "R2 medium limit lag", last_lag, 4);

      // R3: narrow gain, 4 corrections of a quarter clock
      wait_bounds(40);
      check(mode == 2'd2, "R3 narrow after window", int'(mode), 2);
      check(last_lag >= -1 && last_lag <= 1, "R3 relocked before narrow step", last_lag, 0);
      tx_off += 8;
      wait_bounds(9);
      check(last_lag >= 6 && last_lag <= 8, "R3 narrow limit lag", last_lag, 7);

      // R5: freewheel, no correction
      hold_n = 1'b0;
      cyc_wait(1);
      check(mode == 2'd3, "R5 freewheel mode", int'(mode), 3);
      wait_bounds(2);
      l0 = last_lag;
      tx_off += 8;
      wait_bounds(9);
      check(last_lag == l0 + 8, "R5 freewheel lag unchanged by data", last_lag, l0 + 8);
      check(rise_gap == 64, "R5 freewheel rise spacing", rise_gap, 64);

      // R6: hold ignored in acquire
      acq = 1'b1;
      cyc_wait(1);
      check(mode == 2'd0, "R6 acquire with hold low", int'(mode), 0);
      wait_bounds(40);
      check(last_lag >= -1 && last_lag <= 1, "R6 relock with hold low", last_lag, 0);
      hold_n = 1'b1;

      // R8: bad crossing clears quality, good crossings restore it
      check(quality == 1'b1, "R8 quality before step", int'(quality), 1);
      tx_off += 20;
      wait_bounds(1);
      cyc_wait(3);
      check(quality == 1'b0, "R8 bad crossing", int'(quality), 0);
      wait_bounds(40);
      check(quality == 1'b1, "R8 recovered quality", int'(quality), 1);

      // R9: retimed data with 1100 pattern
      pat_pairs = 1'b1;
      wait_bounds(40);
      data_chk = 8;
      wait_bounds(20);
      check(data_chk == 0, "R9 data checks completed", data_chk, 0);

      // R7: powersave
      psave = 1'b1;
      cyc_wait(3);
      check(rx_data == 1'b0, "R7 rx_data in powersave", int'(rx_data), 0);
      check(quality == 1'b0, "R7 quality in powersave", int'(quality), 0);
      r0 = n_rise;
      cyc_wait(320);
      check(n_rise - r0 >= 4, "R7 clock runs in powersave", n_rise - r0, 5);
      psave = 1'b0;

      // R10: no tick, no clock movement
      sample_tick = 1'b0;
      cyc_wait(2);
      c0 = rx_clk;
      r0 = n_rise;
      cyc_wait(150);
      check(rx_clk == c0, "R10 rx_clk frozen", int'(rx_clk), int'(c0));
      check(n_rise == r0, "R10 no rises without tick", n_rise - r0, 0);
      sample_tick = 1'b1;

      // R3: medium window length in rx_clk rises
      acq = 1'b1;
      wait_bounds(40);
      wait_rises(1);
      acq = 1'b0;
      r0 = n_rise;
      guard = 0;
      while (mode != 2'd2 && guard < 4000) begin cyc_wait(1); guard++; end
      cyc_wait(1);
      check(n_rise - r0 == 30, "R3 medium window length", n_rise - r0, 30);

      // R4: restart of the window on a new fall
      acq = 1'b1;
      cyc_wait(2);
      wait_rises(1);
      acq = 1'b0;
      wait_rises(10);
      check(mode == 2'd1, "R4 still medium after 10 bits", int'(mode), 1);
      acq = 1'b1;
      cyc_wait(2);
      acq = 1'b0;
      r0 = n_rise;
      guard = 0;
      while (mode != 2'd2 && guard < 4000) begin cyc_wait(1); guard++; end
      cyc_wait(1);
      check(n_rise - r0 == 30, "R4 window restarted", n_rise - r0, 30);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule